// File: doc/BRIEF.md
# Receive Frame Filter

This block sits on the receive path after the framing logic. It sees a byte-wide frame stream marked with start and end flags, plus a few classification results that come from the address and type logic upstream of it. For each frame it decides whether to pass the frame on or throw it away. It can also remove the four-byte frame check sequence from frames it passes on. A frame that is thrown away leaves nothing on the output stream. For this reason every frame is held in an internal buffer until its last byte arrives, and only then is the frame either released or erased.

The decision combines four checks. The first is a CRC or truncation indication, which can be ignored when checking is turned off in configuration. The second is an address test, which the promiscuous settings can relax. The third looks for flow-control (pause) frames, which are discarded unless passing them is enabled. The fourth is a window on the data length.

For every accepted frame the block also sends the statistics logic a set of single-cycle event pulses and the frame's byte count. Reception starts only at a start-of-frame flag seen while the block is enabled. A frame that is already under way is always completed.

Top module: `rx_frame_filter`

## Requirements
- R1: While reset is held and on the first cycles after it, `outValid` and all event pulses are low.
- R2: A frame that is not dropped appears on the output with its bytes unchanged and in order. `outSop` is set on its first beat, `outEop` on its last beat, and the beats follow one another on consecutive cycles. With stripping off, the output frame has the same number of bytes as the input frame.
- R3: With `cfgStripFcs` set, a forwarded frame loses its last 4 bytes, and `outEop` marks the byte just before them.
- R4: A frame whose end beat carries `inCrcErr` or `inTrunc` raises `evtCrcErr`. Such a frame is dropped when `cfgCrcCheckDis` is 0 and forwarded when it is 1.
- R5: A frame is dropped unless at least one of these holds on its end beat: `addrMatch`, `isBcast`, `cfgPromiscUni`, or `isMcast` together with `cfgPromiscGroup`.
- R6: A frame with `isPause` on its end beat raises `evtPause`. It is dropped unless `cfgPassPause` is 1.
- R7: The data length is the beat count minus 4, or 0 for frames shorter than 4 beats. A frame is dropped unless 64 <= length <= min(`cfgMaxLen`, 9216).
- R8: A frame whose start beat arrives while `cfgEnable` is 0 is ignored completely: it produces no output and no events, even if enable rises during the frame. A frame whose start beat arrives while `cfgEnable` is 1 is processed in full, even if enable falls during the frame.
- R9: A dropped frame produces no output beats.
- R10: One cycle after each accepted frame's end beat, `evtRx` pulses for exactly one cycle. In that same cycle, `evtByteCnt` carries the input beat count. `evtDrop`, `evtCrcErr`, `evtPause`, `evtBcast` and `evtMcast` give that frame's flags, and they pulse only together with `evtRx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Input frame byte |
| inValid | input | 1 | Input beat valid |
| inSop | input | 1 | First beat of a frame |
| inEop | input | 1 | Last beat of a frame |
| inCrcErr | input | 1 | Upstream CRC mismatch, read on the end beat |
| inTrunc | input | 1 | Upstream truncation, read on the end beat |
| addrMatch | input | 1 | Destination address matched, read on the end beat |
| isBcast | input | 1 | Broadcast frame, read on the end beat |
| isMcast | input | 1 | Multicast frame, read on the end beat |
| isPause | input | 1 | Flow-control frame, read on the end beat |
| cfgEnable | input | 1 | Reception enable, read at a start beat |
| cfgCrcCheckDis | input | 1 | Do not drop frames with CRC errors |
| cfgStripFcs | input | 1 | Remove trailing 4 bytes from forwarded frames |
| cfgPassPause | input | 1 | Forward flow-control frames |
| cfgPromiscUni | input | 1 | Accept any destination address |
| cfgPromiscGroup | input | 1 | Accept any multicast frame |
| cfgMaxLen | input | 14 | Maximum data length |
| outData | output | 8 | Output frame byte |
| outValid | output | 1 | Output beat valid |
| outSop | output | 1 | First output beat of a frame |
| outEop | output | 1 | Last output beat of a frame |
| evtRx | output | 1 | Frame-received pulse |
| evtDrop | output | 1 | Frame-dropped pulse |
| evtCrcErr | output | 1 | CRC-error pulse |
| evtPause | output | 1 | Pause-frame pulse |
| evtBcast | output | 1 | Broadcast-frame pulse |
| evtMcast | output | 1 | Multicast-frame pulse |
| evtByteCnt | output | 14 | Input byte count of the frame, valid with evtRx |

## Verification
Two cases are the hardest to reach from the ports. The first is the 9216-byte cap on the length limit. It only shows when `cfgMaxLen` is set above the cap and frames of 9220 and 9221 beats are sent, so the bench builds the buffer deep enough to hold such a frame. The second is a change of `cfgEnable` in the middle of a frame. The driver toggles the enable at a chosen beat inside the frame, in both directions. A frame that must leave no trace is checked through the output-beat and event counters in the monitor. Both counters must be unchanged once the stream has drained.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W = 14;
  localparam logic [LEN_W-1:0] FCS_BYTES   = 14'd4;
  localparam logic [LEN_W-1:0] MIN_DATA    = 14'd64;
  localparam logic [LEN_W-1:0] MAX_DATA_CAP = 14'd9216;
  localparam logic [LEN_W-1:0] CNT_SAT     = {LEN_W{1'b1}};

  // strobes from control to datapath
  typedef struct packed {
    logic             wrByte;
    logic             commit;
    logic             rewind;
    logic [LEN_W-1:0] commitLen;
  } dpStrobe_t;

  typedef enum logic [0:0] {C_IDLE, C_TAKE} ctlState_t;
endpackage

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             inCrcErr,
  input  logic             inTrunc,
  input  logic             addrMatch,
  input  logic             isBcast,
  input  logic             isMcast,
  input  logic             isPause,
  input  logic             cfgEnable,
  input  logic             cfgCrcCheckDis,
  input  logic             cfgStripFcs,
  input  logic             cfgPassPause,
  input  logic             cfgPromiscUni,
  input  logic             cfgPromiscGroup,
  input  logic [LEN_W-1:0] cfgMaxLen,
  input  logic             bufFull,
  input  logic             lenFull,
  output dpStrobe_t        strb,
  output logic             evtRx,
  output logic             evtDrop,
  output logic             evtCrcErr,
  output logic             evtPause,
  output logic             evtBcast,
  output logic             evtMcast,
  output logic [LEN_W-1:0] evtByteCnt
);
  ctlState_t        state;
  logic [LEN_W-1:0] beatCnt;
  logic             frameOvf;

  logic             beatTaken, firstBeat, lastBeat;
  logic [LEN_W-1:0] curCount, dataLen, effMax;
  logic             ovfNow, crcBad, dropCrc, addrOk, dropAddr, dropPause, dropLen;
  logic             wantFwd;

  always_comb begin
    firstBeat = (state == C_IDLE);
    // enable only matters at the start beat
    beatTaken = inValid && ((firstBeat && inSop && cfgEnable) || !firstBeat);
    lastBeat  = beatTaken && inEop;
    if (firstBeat)                curCount = 14'd1;
    else if (beatCnt == CNT_SAT)  curCount = beatCnt;
    else                          curCount = beatCnt + 14'd1;
    ovfNow    = (!firstBeat && frameOvf) || bufFull;
    dataLen   = (curCount > FCS_BYTES) ? (curCount - FCS_BYTES) : '0;
    effMax    = (cfgMaxLen > MAX_DATA_CAP) ? MAX_DATA_CAP : cfgMaxLen;
    crcBad    = inCrcErr || inTrunc;
    dropCrc   = crcBad && !cfgCrcCheckDis;
    addrOk    = addrMatch || isBcast || cfgPromiscUni || (isMcast && cfgPromiscGroup);
    dropAddr  = !addrOk;
    dropPause = isPause && !cfgPassPause;
    dropLen   = (dataLen < MIN_DATA) || (dataLen > effMax);
    wantFwd   = !(dropCrc || dropAddr || dropPause || dropLen || ovfNow || lenFull);

    strb           = '0;
    strb.wrByte    = beatTaken;
    strb.commit    = lastBeat && wantFwd;
    strb.rewind    = lastBeat && !wantFwd;
    strb.commitLen = cfgStripFcs ? (curCount - FCS_BYTES) : curCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= C_IDLE;
      beatCnt    <= '0;
      frameOvf   <= 1'b0;
      evtRx      <= 1'b0;
      evtDrop    <= 1'b0;
      evtCrcErr  <= 1'b0;
      evtPause   <= 1'b0;
      evtBcast   <= 1'b0;
      evtMcast   <= 1'b0;
      evtByteCnt <= '0;
    end else begin
      if (beatTaken) begin
        state    <= inEop ? C_IDLE : C_TAKE;
        beatCnt  <= curCount;
        frameOvf <= ovfNow;
      end
      evtRx      <= lastBeat;
      evtDrop    <= lastBeat && !wantFwd;
      evtCrcErr  <= lastBeat && crcBad;
      evtPause   <= lastBeat && isPause;
      evtBcast   <= lastBeat && isBcast;
      evtMcast   <= lastBeat && isMcast;
      evtByteCnt <= lastBeat ? curCount : '0;
    end
  end

  // R10: the receive pulse follows an input end beat
  a_r10_pulse_after_eop: assert property (@(posedge clk) disable iff (!rstN)
    evtRx |-> $past(inValid && inEop));

  // R10: per-frame flags only appear together with the receive pulse
  a_r10_flags_with_rx: assert property (@(posedge clk) disable iff (!rstN)
    (evtDrop || evtCrcErr || evtPause || evtBcast || evtMcast) |-> evtRx);

  // R4: a CRC error with checking active always drops
  a_r4_crc_drop: assert property (@(posedge clk) disable iff (!rstN)
    (evtCrcErr && !$past(cfgCrcCheckDis)) |-> evtDrop);

  // R6: a pause frame that is not passed is dropped
  a_r6_pause_drop: assert property (@(posedge clk) disable iff (!rstN)
    (evtPause && !$past(cfgPassPause)) |-> evtDrop);

  // R7: a frame below the minimum data length is dropped
  a_r7_short_drop: assert property (@(posedge clk) disable iff (!rstN)
    (evtRx && (evtByteCnt < (MIN_DATA + FCS_BYTES))) |-> evtDrop);
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int BUF_DEPTH   = 2048,
  parameter int LFIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  dpStrobe_t  strb,
  output logic       bufFull,
  output logic       lenFull,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outSop,
  output logic       outEop
);
  localparam int AW  = $clog2(BUF_DEPTH);
  localparam int PW  = AW + 1;
  localparam int LAW = $clog2(LFIFO_DEPTH);
  localparam int LPW = LAW + 1;

  logic [7:0]       mem    [BUF_DEPTH];
  logic [LEN_W-1:0] lenMem [LFIFO_DEPTH];

  logic [PW-1:0]    wrPtr, basePtr, rdPtr;
  logic [LPW-1:0]   lwPtr, lrPtr;
  logic [LEN_W-1:0] remain, headLen;
  logic [PW-1:0]    nextBase;
  logic             lenEmpty, popNow, doWrite;

  assign bufFull  = (wrPtr - rdPtr) == PW'(BUF_DEPTH);
  assign lenFull  = (lwPtr - lrPtr) == LPW'(LFIFO_DEPTH);
  assign lenEmpty = (lwPtr == lrPtr);
  assign headLen  = lenMem[lrPtr[LAW-1:0]];
  assign popNow   = (remain == '0) && !lenEmpty;
  assign doWrite  = strb.wrByte && !bufFull;
  assign nextBase = basePtr + PW'(strb.commitLen);

  // frame byte storage
  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr[AW-1:0]] <= inData;
  end

  // committed frame lengths
  always_ff @(posedge clk) begin
    if (strb.commit) lenMem[lwPtr[LAW-1:0]] <= strb.commitLen;
  end

  // write side: speculative pointer, committed base
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      basePtr <= '0;
      lwPtr   <= '0;
    end else if (strb.commit) begin
      basePtr <= nextBase;
      wrPtr   <= nextBase;
      lwPtr   <= lwPtr + LPW'(1);
    end else if (strb.rewind) begin
      wrPtr   <= basePtr;
    end else if (doWrite) begin
      wrPtr   <= wrPtr + PW'(1);
    end
  end

  // read side: drains committed frames one byte per cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      lrPtr    <= '0;
      remain   <= '0;
      outData  <= '0;
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
    end else if (popNow) begin
      outData  <= mem[rdPtr[AW-1:0]];
      outValid <= 1'b1;
      outSop   <= 1'b1;
      outEop   <= (headLen == 14'd1);
      remain   <= headLen - 14'd1;
      rdPtr    <= rdPtr + PW'(1);
      lrPtr    <= lrPtr + LPW'(1);
    end else if (remain != '0) begin
      outData  <= mem[rdPtr[AW-1:0]];
      outValid <= 1'b1;
      outSop   <= 1'b0;
      outEop   <= (remain == 14'd1);
      remain   <= remain - 14'd1;
      rdPtr    <= rdPtr + PW'(1);
    end else begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
    end
  end

  // R9: the writer never runs over unread bytes
  a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - rdPtr) <= PW'(BUF_DEPTH));

  // R9: a frame end is either kept or erased, never both
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit && strb.rewind));

  // R9: a commit is only issued with room for its length
  a_r9_len_room: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !lenFull);

  // R2: frame beats are contiguous on the output
  a_r2_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outEop) |=> (outValid && !outSop));
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int BUF_DEPTH   = 2048,
  parameter int LFIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             inCrcErr,
  input  logic             inTrunc,
  input  logic             addrMatch,
  input  logic             isBcast,
  input  logic             isMcast,
  input  logic             isPause,
  input  logic             cfgEnable,
  input  logic             cfgCrcCheckDis,
  input  logic             cfgStripFcs,
  input  logic             cfgPassPause,
  input  logic             cfgPromiscUni,
  input  logic             cfgPromiscGroup,
  input  logic [13:0]      cfgMaxLen,
  output logic [7:0]       outData,
  output logic             outValid,
  output logic             outSop,
  output logic             outEop,
  output logic             evtRx,
  output logic             evtDrop,
  output logic             evtCrcErr,
  output logic             evtPause,
  output logic             evtBcast,
  output logic             evtMcast,
  output logic [13:0]      evtByteCnt
);
  dpStrobe_t strb;
  logic      bufFull, lenFull;

  rxf_control ctl_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inCrcErr(inCrcErr), .inTrunc(inTrunc),
    .addrMatch(addrMatch), .isBcast(isBcast), .isMcast(isMcast), .isPause(isPause),
    .cfgEnable(cfgEnable), .cfgCrcCheckDis(cfgCrcCheckDis), .cfgStripFcs(cfgStripFcs),
    .cfgPassPause(cfgPassPause), .cfgPromiscUni(cfgPromiscUni),
    .cfgPromiscGroup(cfgPromiscGroup), .cfgMaxLen(cfgMaxLen),
    .bufFull(bufFull), .lenFull(lenFull), .strb(strb),
    .evtRx(evtRx), .evtDrop(evtDrop), .evtCrcErr(evtCrcErr), .evtPause(evtPause),
    .evtBcast(evtBcast), .evtMcast(evtMcast), .evtByteCnt(evtByteCnt)
  );

  rxf_datapath #(.BUF_DEPTH(BUF_DEPTH), .LFIFO_DEPTH(LFIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb),
    .bufFull(bufFull), .lenFull(lenFull),
    .outData(outData), .outValid(outValid), .outSop(outSop), .outEop(outEop)
  );
endmodule

// File: tb/rx_frame_filter_tb_top.sv
module rx_frame_filter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 0, inSop = 0, inEop = 0, inCrcErr = 0, inTrunc = 0;
  logic addrMatch = 0, isBcast = 0, isMcast = 0, isPause = 0;
  logic cfgEnable = 1, cfgCrcCheckDis = 0, cfgStripFcs = 0, cfgPassPause = 0;
  logic cfgPromiscUni = 0, cfgPromiscGroup = 0;
  logic [13:0] cfgMaxLen = 14'd1518;
  logic [7:0] outData;
  logic outValid, outSop, outEop;
  logic evtRx, evtDrop, evtCrcErr, evtPause, evtBcast, evtMcast;
  logic [13:0] evtByteCnt;

  always #10 clk = ~clk;

  rx_frame_filter #(.BUF_DEPTH(16384), .LFIFO_DEPTH(8)) dut_i (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inSop(inSop),
    .inEop(inEop), .inCrcErr(inCrcErr), .inTrunc(inTrunc), .addrMatch(addrMatch),
    .isBcast(isBcast), .isMcast(isMcast), .isPause(isPause), .cfgEnable(cfgEnable),
    .cfgCrcCheckDis(cfgCrcCheckDis), .cfgStripFcs(cfgStripFcs),
    .cfgPassPause(cfgPassPause), .cfgPromiscUni(cfgPromiscUni),
    .cfgPromiscGroup(cfgPromiscGroup), .cfgMaxLen(cfgMaxLen),
    .outData(outData), .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .evtRx(evtRx), .evtDrop(evtDrop), .evtCrcErr(evtCrcErr), .evtPause(evtPause),
    .evtBcast(evtBcast), .evtMcast(evtMcast), .evtByteCnt(evtByteCnt)
  );

  int checks = 0;
  int errors = 0;
  int outSeen = 0;
  int evSeen = 0;
  logic [7:0] seed = 8'h10;

  logic [9:0]  expOut[$];
  string       outTag[$];
  logic [18:0] expEv[$];
  string       evTag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver: sends a frame and pushes its expected results
  task automatic sendFrame(input int beats, input string tag, input bit crc, input bit trunc,
                           input bit match, input bit bc, input bit mc, input bit pause,
                           input int flipAt);
    bit enAtSop, crcBad, drop;
    int dlen, effMax, nOut;
    enAtSop = cfgEnable;
    crcBad  = crc | trunc;
    effMax  = (cfgMaxLen > 9216) ? 9216 : int'(cfgMaxLen);
    dlen    = (beats > 4) ? beats - 4 : 0;
    drop    = (crcBad && !cfgCrcCheckDis) ||
              !(match || bc || cfgPromiscUni || (mc && cfgPromiscGroup)) ||
              (pause && !cfgPassPause) || (dlen < 64) || (dlen > effMax);
    if (enAtSop) begin
      expEv.push_back({drop, crcBad, pause, bc, mc, 14'(beats)});
      evTag.push_back(tag);
      if (!drop) begin
        nOut = cfgStripFcs ? beats - 4 : beats;
        for (int k = 0; k < nOut; k++) begin
          expOut.push_back({(k == 0), (k == nOut - 1), 8'(seed + 8'(k))});
          outTag.push_back(tag);
        end
      end
    end
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      inValid   = 1;
      inSop     = (i == 0);
      inEop     = (i == beats - 1);
      inData    = 8'(seed + 8'(i));
      inCrcErr  = (i == beats - 1) && crc;
      inTrunc   = (i == beats - 1) && trunc;
      addrMatch = (i == beats - 1) && match;
      isBcast   = (i == beats - 1) && bc;
      isMcast   = (i == beats - 1) && mc;
      isPause   = (i == beats - 1) && pause;
      if (i == flipAt) cfgEnable = !cfgEnable;
    end
    @(negedge clk);
    inValid = 0; inSop = 0; inEop = 0; inCrcErr = 0; inTrunc = 0;
    addrMatch = 0; isBcast = 0; isMcast = 0; isPause = 0;
    seed = seed + 8'h25;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expOut.size() != 0 || expEv.size() != 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
  endtask

  // monitor: compares output beats and event pulses against the queues
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        outSeen++;
        if (expOut.size() == 0) begin
          check(0, "R9 unexpected output beat", {outSop, outEop, outData}, 0);
        end else begin
          logic [9:0] e;
          string t;
          e = expOut.pop_front();
          t = outTag.pop_front();
          check({outSop, outEop, outData} == e, {"R2 beat (", t, ")"},
                {outSop, outEop, outData}, e);
        end
      end
      if (evtRx) begin
        evSeen++;
        if (expEv.size() == 0) begin
          check(0, "R10 unexpected event", evtByteCnt, 0);
        end else begin
          logic [18:0] e;
          string t;
          e = expEv.pop_front();
          t = evTag.pop_front();
          check({evtDrop, evtCrcErr, evtPause, evtBcast, evtMcast, evtByteCnt} == e,
                {"R10 event (", t, ")"},
                {evtDrop, evtCrcErr, evtPause, evtBcast, evtMcast, evtByteCnt}, e);
        end
      end else if (evtDrop || evtCrcErr || evtPause || evtBcast || evtMcast) begin
        check(0, "R10 flag without receive pulse",
              {evtDrop, evtCrcErr, evtPause, evtBcast, evtMcast}, 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int mark;
    repeat (4) @(negedge clk);
    check(outValid == 0 && evtRx == 0, "R1 in reset", {outValid, evtRx}, 0);
    rstN = 1;
    @(negedge clk);
    check(outValid == 0 && evtRx == 0 && evtDrop == 0, "R1 after reset",
          {outValid, evtRx, evtDrop}, 0);

    // R2 plain forward
    sendFrame(70, "R2", 0, 0, 1, 0, 0, 0, -1);
    sendFrame(100, "R2", 0, 0, 1, 0, 0, 0, -1);
    // R3 strip
    cfgStripFcs = 1;
    sendFrame(80, "R3", 0, 0, 1, 0, 0, 0, -1);
    cfgStripFcs = 0;
    // R4 CRC handling
    drain();
    mark = outSeen;
    sendFrame(72, "R4", 1, 0, 1, 0, 0, 0, -1);
    drain();
    check(outSeen == mark, "R9 crc-dropped frame left no beats", outSeen - mark, 0);
    cfgCrcCheckDis = 1;
    sendFrame(72, "R4", 1, 0, 1, 0, 0, 0, -1);
    cfgCrcCheckDis = 0;
    sendFrame(72, "R4", 0, 1, 1, 0, 0, 0, -1);
    // R5 address
    sendFrame(70, "R5", 0, 0, 0, 0, 0, 0, -1);
    sendFrame(70, "R5", 0, 0, 0, 1, 0, 0, -1);
    sendFrame(70, "R5", 0, 0, 0, 0, 1, 0, -1);
    cfgPromiscGroup = 1;
    sendFrame(70, "R5", 0, 0, 0, 0, 1, 0, -1);
    cfgPromiscGroup = 0;
    cfgPromiscUni = 1;
    sendFrame(70, "R5", 0, 0, 0, 0, 0, 0, -1);
    cfgPromiscUni = 0;
    // R6 pause
    sendFrame(68, "R6", 0, 0, 1, 0, 1, 1, -1);
    cfgPassPause = 1;
    sendFrame(68, "R6", 0, 0, 1, 0, 1, 1, -1);
    cfgPassPause = 0;
    // R7 length window
    sendFrame(1, "R7", 0, 0, 1, 0, 0, 0, -1);
    sendFrame(67, "R7", 0, 0, 1, 0, 0, 0, -1);
    sendFrame(68, "R7", 0, 0, 1, 0, 0, 0, -1);
    cfgMaxLen = 14'd100;
    sendFrame(104, "R7", 0, 0, 1, 0, 0, 0, -1);
    sendFrame(105, "R7", 0, 0, 1, 0, 0, 0, -1);
    cfgMaxLen = 14'd16383;
    sendFrame(9220, "R7", 0, 0, 1, 0, 0, 0, -1);
    sendFrame(9221, "R7", 0, 0, 1, 0, 0, 0, -1);
    drain();
    cfgMaxLen = 14'd1518;
    // R8 enable sampled at start only
    cfgEnable = 0;
    mark = evSeen;
    sendFrame(70, "R8", 0, 0, 1, 0, 0, 0, 10);
    drain();
    check(evSeen == mark, "R8 frame started while disabled raised events", evSeen - mark, 0);
    check(cfgEnable == 1, "R8 bench enable restored", cfgEnable, 1);
    sendFrame(70, "R8", 0, 0, 1, 0, 0, 0, 10);
    cfgEnable = 1;
    sendFrame(69, "R8", 0, 0, 1, 1, 0, 0, -1);
    drain();

    check(expOut.size() == 0, "R9 leftover expected beats", expOut.size(), 0);
    check(expEv.size() == 0, "R10 leftover expected events", expEv.size(), 0);
    summary();
    $finish;
  end
endmodule